// File: doc/BRIEF.md
# Supervisor Counter-Inhibit Alias

This block gives supervisor software a window onto the machine-level counter-inhibit bits of a RISC-V style hart. It owns the 32 machine inhibit bits, which freeze the cycle counter, the instructions-retired counter and hardware performance counters 3 to 31. It also answers CSR requests aimed at the supervisor alias address. The alias holds no storage of its own. A read returns the machine bits filtered by the supervisor counter-enable mask, with bit 1 always zero. A permitted write changes only those filtered bits in the machine register.

Each request carries the hart's current privilege mode. A counter-delegation enable bit decides which modes are refused. With the enable clear, a machine-mode access raises an illegal-instruction exception. With the enable set, an access from a virtualised supervisor or user mode raises a virtual-instruction exception. The exception and the read data come back combinationally in the cycle of the request. The machine bits change at the clock edge that ends that cycle. The inhibit bits leave the block on a dedicated output that feeds the counters.

Top module: `sinh_alias_csr`

## Requirements
- R1: After synchronous reset all 32 machine inhibit bits on `inh_q` are 0.
- R2: Only a request with `req_valid`=1 and `req_addr`=0x120 is served. Any other cycle gives `rd_data`=0 and `exc_valid`=0, and leaves `inh_q` unchanged.
- R3: When `deleg_en`=0 and `priv`=3 (machine), a served access gives `exc_valid`=1 with `exc_code`=2. Privilege encoding: 0 user, 1 supervisor, 3 machine, 4 virtual user, 5 virtual supervisor.
- R4: When `deleg_en`=1 and `priv` is 4 or 5, a served access gives `exc_valid`=1 with `exc_code`=22.
- R5: Every other combination of `deleg_en` and `priv` is permitted, with `exc_valid`=0. This includes supervisor with the enable clear and machine with the enable set.
- R6: A permitted access returns `rd_data` = `inh_q` AND `deleg_mask`, with bit 1 forced to 0. Bit 0 is the cycle-counter inhibit, bit 2 the instructions-retired inhibit, and bit n for n from 3 to 31 the inhibit for performance counter n.
- R7: A permitted access with `req_op`=1 (write) loads each bit that is enabled in `deleg_mask`, other than bit 1, from `req_wdata` at the next clock edge.
- R8: `req_op`=2 (set) ORs `req_wdata` into the enabled bits. `req_op`=3 (clear) clears the enabled bits where `req_wdata` is 1. `req_op`=0 (read) modifies nothing.
- R9: A served request never changes bit 1, or any bit that is clear in `deleg_mask`.
- R10: An access that raises an exception returns `rd_data`=0 and leaves `inh_q` unchanged.
- R11: `exc_valid` is high only in a cycle that carries a served request, and `exc_code` is 0 whenever `exc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 12 | CSR address |
| req_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| req_wdata | input | 32 | Write or set/clear operand |
| priv | input | 3 | Current privilege mode |
| deleg_en | input | 1 | Counter-delegation enable |
| deleg_mask | input | 32 | Supervisor counter-enable mask |
| rd_data | output | 32 | Alias read value |
| exc_valid | output | 1 | Exception raised by this request |
| exc_code | output | 5 | Exception cause code |
| inh_q | output | 32 | Machine counter-inhibit bits |

## Verification
The bench sweeps every privilege code, both enable values and all four operations. It does this against several mask and data patterns, using an arithmetic model. The model exposes designs that swap the two exception rules, refuse supervisor accesses when the enable is clear, or let machine mode through when it should trap. Masks that clear bits 0 and 2 catch a design that lets writes reach bits supervisor cannot see. Writes of all ones catch a design that lets bit 1 leak into a read or a write. Off-address and strobe-low cycles catch a decoder that answers or updates without a valid hit.

// File: rtl/sinh_pkg.sv
package sinh_pkg;

    localparam int XLEN       = 32;
    localparam int ADDR_W     = 12;
    localparam int PRIV_W     = 3;
    localparam int OP_W       = 2;
    localparam int CODE_W     = 5;
    localparam int GAP_BIT    = 1;

    localparam logic [ADDR_W-1:0] ALIAS_ADDR = 12'h120;

    typedef enum logic [PRIV_W-1:0] {
        PRIV_U  = 3'd0,
        PRIV_S  = 3'd1,
        PRIV_RS = 3'd2,
        PRIV_M  = 3'd3,
        PRIV_VU = 3'd4,
        PRIV_VS = 3'd5,
        PRIV_X6 = 3'd6,
        PRIV_X7 = 3'd7
    } priv_e;

    typedef enum logic [OP_W-1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    typedef enum logic [CODE_W-1:0] {
        EXC_NONE    = 5'd0,
        EXC_ILLEGAL = 5'd2,
        EXC_VIRTUAL = 5'd22
    } exc_e;

    typedef struct packed {
        logic             valid;
        exc_e             code;
    } exc_t;

    function automatic logic is_virtual(priv_e p);
        return (p == PRIV_VU) || (p == PRIV_VS);
    endfunction

    function automatic logic is_machine(priv_e p);
        return p == PRIV_M;
    endfunction

    function automatic logic [XLEN-1:0] gap_clear(logic [XLEN-1:0] m);
        logic [XLEN-1:0] r;
        r = m;
        r[GAP_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/sinh_access_gate.sv
module sinh_access_gate
    import sinh_pkg::*;
(
    input  logic  hit,
    input  priv_e mode,
    input  logic  deleg_en,
    output exc_t  exc,
    output logic  allow
);
    logic trap_illegal;
    logic trap_virtual;

    always_comb begin
        trap_illegal = hit && !deleg_en && is_machine(mode);
        trap_virtual = hit && deleg_en && is_virtual(mode);
        exc.valid    = trap_illegal || trap_virtual;
        if (trap_illegal)
            exc.code = EXC_ILLEGAL;
        else if (trap_virtual)
            exc.code = EXC_VIRTUAL;
        else
            exc.code = EXC_NONE;
        allow = hit && !exc.valid;
    end
endmodule

// File: rtl/sinh_alias_merge.sv
module sinh_alias_merge
    import sinh_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] wdata,
    input  op_e          op,
    output logic [W-1:0] view,
    output logic [W-1:0] nxt,
    output logic         touch
);
    logic [W-1:0] eff;

    assign eff   = gap_clear(mask);
    assign touch = (op != OP_READ);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic shown;
        logic upd;
        assign shown = cur[b] & eff[b];
        always_comb begin
            unique case (op)
                OP_WRITE: upd = wdata[b];
                OP_SET:   upd = shown | wdata[b];
                OP_CLEAR: upd = shown & ~wdata[b];
                default:  upd = shown;
            endcase
        end
        assign view[b] = shown;
        assign nxt[b]  = eff[b] ? upd : cur[b];
    end
endmodule

// File: rtl/sinh_inhibit_store.sv
module sinh_inhibit_store #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= d;
    end
endmodule

// File: rtl/sinh_alias_csr.sv
module sinh_alias_csr
    import sinh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [OP_W-1:0]   req_op,
    input  logic [XLEN-1:0]   req_wdata,
    input  logic [PRIV_W-1:0] priv,
    input  logic              deleg_en,
    input  logic [XLEN-1:0]   deleg_mask,
    output logic [XLEN-1:0]   rd_data,
    output logic              exc_valid,
    output logic [CODE_W-1:0] exc_code,
    output logic [XLEN-1:0]   inh_q
);
    logic            hit;
    logic            allow;
    exc_t            exc;
    logic [XLEN-1:0] view;
    logic [XLEN-1:0] nxt;
    logic            touch;

    assign hit = req_valid && (req_addr == ALIAS_ADDR);

    sinh_access_gate u_gate (
        .hit      (hit),
        .mode     (priv_e'(priv)),
        .deleg_en (deleg_en),
        .exc      (exc),
        .allow    (allow)
    );

    sinh_alias_merge #(.W(XLEN)) u_merge (
        .cur   (inh_q),
        .mask  (deleg_mask),
        .wdata (req_wdata),
        .op    (op_e'(req_op)),
        .view  (view),
        .nxt   (nxt),
        .touch (touch)
    );

    sinh_inhibit_store #(.W(XLEN)) u_store (
        .clk (clk),
        .rst (rst),
        .we  (allow && touch),
        .d   (nxt),
        .q   (inh_q)
    );

    assign rd_data   = allow ? view : '0;
    assign exc_valid = exc.valid;
    assign exc_code  = exc.code;
endmodule

// File: rtl/sinh_alias_csr_chk.sv
module sinh_alias_csr_chk
    import sinh_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [OP_W-1:0]   req_op,
    input logic [XLEN-1:0]   deleg_mask,
    input logic [XLEN-1:0]   rd_data,
    input logic              exc_valid,
    input logic [CODE_W-1:0] exc_code,
    input logic [XLEN-1:0]   inh_q
);
    logic hit;
    assign hit = req_valid && (req_addr == ALIAS_ADDR);

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> inh_q == '0);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(inh_q));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (rd_data == '0 && !exc_valid));

    p_code_legal_r3: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> (exc_code == 5'd2 || exc_code == 5'd22));

    p_gap_read_r6: assert property (@(posedge clk) disable iff (rst)
        rd_data[GAP_BIT] == 1'b0);

    p_read_only_r8: assert property (@(posedge clk) disable iff (rst)
        (hit && req_op == 2'd0) |=> $stable(inh_q));

    p_hidden_hold_r9: assert property (@(posedge clk) disable iff (rst)
        hit |=> ((inh_q & ~gap_clear($past(deleg_mask)))
                 == ($past(inh_q) & ~gap_clear($past(deleg_mask)))));

    p_trap_hold_r10: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> $stable(inh_q));

    p_trap_zero_r10: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> rd_data == '0);

    p_exc_hit_r11: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> hit);

    p_code_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |-> exc_code == '0);
endmodule

bind sinh_alias_csr sinh_alias_csr_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_op     (req_op),
    .deleg_mask (deleg_mask),
    .rd_data    (rd_data),
    .exc_valid  (exc_valid),
    .exc_code   (exc_code),
    .inh_q      (inh_q)
);

// File: tb/sinh_alias_csr_tb.sv
module sinh_alias_csr_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [11:0] req_addr;
    logic [1:0]  req_op;
    logic [31:0] req_wdata;
    logic [2:0]  priv;
    logic        deleg_en;
    logic [31:0] deleg_mask;
    logic [31:0] rd_data;
    logic        exc_valid;
    logic [4:0]  exc_code;
    logic [31:0] inh_q;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sinh_alias_csr dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_op(req_op), .req_wdata(req_wdata), .priv(priv),
        .deleg_en(deleg_en), .deleg_mask(deleg_mask), .rd_data(rd_data),
        .exc_valid(exc_valid), .exc_code(exc_code), .inh_q(inh_q)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(logic valid, logic [11:0] addr, logic [1:0] op,
                          logic [31:0] wd, logic [2:0] pm, logic en, logic [31:0] msk);
        logic        served, ill, virt, ex;
        logic [31:0] eff, exp_rd, nxt;
        logic [4:0]  exp_code;
        string       tg;
        @(negedge clk);
        req_valid = valid; req_addr = addr; req_op = op; req_wdata = wd;
        priv = pm; deleg_en = en; deleg_mask = msk;
        served   = valid && (addr == 12'h120);
        ill      = served && !en && (pm == 3'd3);
        virt     = served && en && (pm == 3'd4 || pm == 3'd5);
        ex       = ill || virt;
        exp_code = ill ? 5'd2 : (virt ? 5'd22 : 5'd0);
        eff      = msk & ~32'h2;
        exp_rd   = (served && !ex) ? (model & eff) : 32'h0;
        nxt      = model;
        if (served && !ex) begin
            case (op)
                2'd1: nxt = (model & ~eff) | (wd & eff);
                2'd2: nxt = model | (wd & eff);
                2'd3: nxt = model & ~(wd & eff);
                default: nxt = model;
            endcase
        end
        tg = !served ? "R2" : (ill ? "R3" : (virt ? "R4" : "R5"));
        #1;
        check(tg, "exc_valid", {31'b0, exc_valid}, {31'b0, ex});
        check(ex ? "R10" : "R11", "exc_code", {27'b0, exc_code}, {27'b0, exp_code});
        check(ex ? "R10" : (served ? "R6" : "R2"), "rd_data", rd_data, exp_rd);
        @(posedge clk);
        #1;
        model = nxt;
        check(ex ? "R10" : (op == 2'd0 ? "R8" : (op == 2'd1 ? "R7" : "R8")),
              "inh_q", inh_q, model);
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] masks [3];
        logic [31:0] datas [3];
        logic [2:0]  privs [5];
        masks = '{32'hFFFF_FFFF, 32'h0000_0005, 32'hA5A5_F00A};
        datas = '{32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_0000};
        privs = '{3'd0, 3'd1, 3'd3, 3'd4, 3'd5};
        rst = 1'b1; req_valid = 0; req_addr = 0; req_op = 0; req_wdata = 0;
        priv = 0; deleg_en = 0; deleg_mask = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "inh_q after reset", inh_q, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R2: off-address and strobe-low requests
        access(1'b1, 12'h121, 2'd1, 32'hFFFF_FFFF, 3'd1, 1'b1, 32'hFFFF_FFFF);
        access(1'b0, 12'h120, 2'd1, 32'hFFFF_FFFF, 3'd1, 1'b1, 32'hFFFF_FFFF);
        // R7 R9: full write, bit 1 must stay 0
        access(1'b1, 12'h120, 2'd1, 32'hFFFF_FFFF, 3'd1, 1'b1, 32'hFFFF_FFFF);
        check("R9", "bit1 after write", {31'b0, inh_q[1]}, 32'h0);
        // R9: narrow mask write of zeros leaves hidden bits set
        access(1'b1, 12'h120, 2'd1, 32'h0, 3'd1, 1'b1, 32'h0000_0001);
        check("R9", "hidden bits kept", inh_q, 32'hFFFF_FFFC);
        // R10: trapped write leaves state
        access(1'b1, 12'h120, 2'd1, 32'h0, 3'd3, 1'b0, 32'hFFFF_FFFF);
        access(1'b1, 12'h120, 2'd1, 32'h0, 3'd5, 1'b1, 32'hFFFF_FFFF);

        for (int mi = 0; mi < 3; mi++)
            for (int di = 0; di < 3; di++)
                for (int pi = 0; pi < 5; pi++)
                    for (int e = 0; e < 2; e++)
                        for (int o = 0; o < 4; o++)
                            access(1'b1, 12'h120, o[1:0], datas[di] ^ {mi[7:0], 24'h0},
                                   privs[pi], e[0], masks[mi]);

        // R11: no request means no exception
        @(negedge clk);
        priv = 3'd3; deleg_en = 1'b0; req_addr = 12'h120; req_valid = 1'b0;
        #1;
        check("R11", "exc idle", {31'b0, exc_valid}, 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule